// File: doc/BRIEF.md
# Cathode Black-Level Loop Start-Up Sequencer

This block schedules the two-point cathode black-level stabilisation loop of a display drive path and decides when the RGB drive may leave the blanked state after switch-on. It starts with the outputs blanked. While the loop settles, it selects the high-current test measurement and the low-current test measurement in turn, one per field. It also raises a leakage-measurement strobe once in every field. The analog comparison and the DACs sit outside the block and follow these selects.

Three release policies are available. In automatic release, the drive is unblanked as soon as the loop reports that it is stable. In host-held release, a status flag falls when the loop is stable, and the drive stays blanked until the host drops its hold bit. In timed release, the drive is unblanked after a fixed number of field pulses, whatever the loop reports. A service input switches the loop off, forces a fixed black level and stops the vertical scan. Leaving service restarts the whole sequence from the blanked state.

Top module: `cathode_cal_seq`

## Requirements
- R1: During and just after reset, rgb_blank=1, settle_flag=1, loop_enable=1, meas_hi_sel=1, meas_lo_sel=0, leak_meas=0, force_black=0 and vscan_off=0.
- R2: While loop_enable=1, exactly one of meas_hi_sel and meas_lo_sel is 1. The active select swaps on the clock edge that samples field_pulse=1. While loop_enable=0, both selects are 0.
- R3: leak_meas is 1 for exactly the cycle after each clock edge that samples field_pulse=1 with service_mode=0. At all other times it is 0.
- R4: In the blanked start-up state with timed_release=0 and host_hold=0, the edge that samples loop_stable=1 clears rgb_blank and settle_flag.
- R5: In the blanked start-up state with timed_release=0 and host_hold=1, the edge that samples loop_stable=1 clears settle_flag and keeps rgb_blank=1. rgb_blank then clears on the first edge that samples host_hold=0.
- R6: With timed_release=1 in the blanked start-up state, loop_stable is ignored. rgb_blank clears on the edge that samples the FIELD_DELAY-th field pulse counted in that state. If timed_release drops, the count is cleared.
- R7: The edge that samples service_mode=1 gives loop_enable=0, force_black=1, vscan_off=1, rgb_blank=1 and settle_flag=1. These values hold while service_mode stays 1.
- R8: The first edge that samples service_mode=0 after service restarts the sequence. The block is then blanked, settle_flag=1, the high measurement is selected and the field count is cleared.
- R9: Once released, rgb_blank stays 0 until service_mode is sampled as 1, even if loop_stable or host_hold change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| field_pulse | input | 1 | One-cycle pulse at the start of each field |
| loop_stable | input | 1 | Black-level loop reports convergence |
| host_hold | input | 1 | Host-held release policy; host clears it to release |
| timed_release | input | 1 | Selects release after FIELD_DELAY fields |
| service_mode | input | 1 | Service mode: loop off, fixed black, scan off |
| rgb_blank | output | 1 | Blank the RGB drive |
| settle_flag | output | 1 | Status: 1 while the loop has not been seen stable |
| meas_hi_sel | output | 1 | Select high test-current measurement this field |
| meas_lo_sel | output | 1 | Select low test-current measurement this field |
| leak_meas | output | 1 | Leakage measurement strobe, once per field |
| loop_enable | output | 1 | Black-level loop active |
| force_black | output | 1 | Force fixed black level on RGB outputs |
| vscan_off | output | 1 | Disable vertical scan |

## Verification
The bench drives the block under every release policy and compares it each cycle with a behavioural model. The corner cases it targets are the following. A timed release that counts one field too few or too many would unblank a field early or late. A host-held release that let the drive go when the loop became stable would unblank before the host cleared its bit. A release that re-blanked when loop_stable fell would make the picture flicker after start-up. A service exit that did not restart the sequence would leave the drive unblanked, or the phase or count stale, on the new start.

// File: rtl/cathode_cal_pkg.sv
package cathode_cal_pkg;

    typedef enum logic [1:0] {
        SEQ_BLANK   = 2'd0,
        SEQ_HOLD    = 2'd1,
        SEQ_RUN     = 2'd2,
        SEQ_SERVICE = 2'd3
    } seq_state_t;

    typedef struct packed {
        logic rgb_blank;
        logic settle_flag;
        logic loop_enable;
        logic force_black;
        logic vscan_off;
    } drive_ctl_t;

    function automatic drive_ctl_t decode_state(seq_state_t s);
        drive_ctl_t d;
        d.rgb_blank   = (s != SEQ_RUN);
        d.settle_flag = (s == SEQ_BLANK) || (s == SEQ_SERVICE);
        d.loop_enable = (s != SEQ_SERVICE);
        d.force_black = (s == SEQ_SERVICE);
        d.vscan_off   = (s == SEQ_SERVICE);
        return d;
    endfunction

endpackage

// File: rtl/ccs_phase_gen.sv
module ccs_phase_gen (
    input  logic clk,
    input  logic rst,
    input  logic field_pulse,
    input  logic freeze,
    input  logic restart,
    output logic phase_hi,
    output logic leak_strobe
);
    always_ff @(posedge clk) begin
        if (rst || restart) begin
            phase_hi <= 1'b1;
        end else if (field_pulse && !freeze) begin
            phase_hi <= ~phase_hi;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            leak_strobe <= 1'b0;
        end else begin
            leak_strobe <= field_pulse && !freeze;
        end
    end
endmodule

// File: rtl/ccs_release_timer.sv
module ccs_release_timer #(
    parameter int FIELD_DELAY = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic enable,
    input  logic field_pulse,
    output logic done
);
    localparam int CW = $clog2(FIELD_DELAY + 1);
    localparam logic [CW-1:0] LAST = CW'(FIELD_DELAY - 1);

    logic [CW-1:0] count_q;

    assign done = enable && field_pulse && (count_q == LAST);

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            count_q <= '0;
        end else if (field_pulse) begin
            count_q <= done ? '0 : count_q + 1'b1;
        end
    end
endmodule

// File: rtl/ccs_release_fsm.sv
module ccs_release_fsm
    import cathode_cal_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       service_mode,
    input  logic       loop_stable,
    input  logic       host_hold,
    input  logic       timed_release,
    input  logic       timer_done,
    output seq_state_t state
);
    seq_state_t state_d;

    always_comb begin
        state_d = state;
        if (service_mode) begin
            state_d = SEQ_SERVICE;
        end else begin
            unique case (state)
                SEQ_SERVICE: state_d = SEQ_BLANK;
                SEQ_BLANK: begin
                    if (timed_release) begin
                        if (timer_done) state_d = SEQ_RUN;
                    end else if (loop_stable) begin
                        state_d = host_hold ? SEQ_HOLD : SEQ_RUN;
                    end
                end
                SEQ_HOLD: if (!host_hold) state_d = SEQ_RUN;
                SEQ_RUN:  state_d = SEQ_RUN;
                default:  state_d = SEQ_BLANK;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state <= SEQ_BLANK;
        else     state <= state_d;
    end
endmodule

// File: rtl/cathode_cal_seq.sv
module cathode_cal_seq
    import cathode_cal_pkg::*;
#(
    parameter int FIELD_DELAY = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic field_pulse,
    input  logic loop_stable,
    input  logic host_hold,
    input  logic timed_release,
    input  logic service_mode,
    output logic rgb_blank,
    output logic settle_flag,
    output logic meas_hi_sel,
    output logic meas_lo_sel,
    output logic leak_meas,
    output logic loop_enable,
    output logic force_black,
    output logic vscan_off
);
    seq_state_t state;
    drive_ctl_t ctl;
    logic       timer_en;
    logic       timer_done;
    logic       restart;
    logic       phase_hi;

    assign timer_en = (state == SEQ_BLANK) && timed_release && !service_mode;
    assign restart  = (state == SEQ_SERVICE) && !service_mode;

    ccs_release_timer #(.FIELD_DELAY(FIELD_DELAY)) u_timer (
        .clk(clk), .rst(rst), .enable(timer_en),
        .field_pulse(field_pulse), .done(timer_done)
    );

    ccs_release_fsm u_fsm (
        .clk(clk), .rst(rst), .service_mode(service_mode),
        .loop_stable(loop_stable), .host_hold(host_hold),
        .timed_release(timed_release), .timer_done(timer_done),
        .state(state)
    );

    ccs_phase_gen u_phase (
        .clk(clk), .rst(rst), .field_pulse(field_pulse),
        .freeze(service_mode), .restart(restart),
        .phase_hi(phase_hi), .leak_strobe(leak_meas)
    );

    assign ctl         = decode_state(state);
    assign rgb_blank   = ctl.rgb_blank;
    assign settle_flag = ctl.settle_flag;
    assign loop_enable = ctl.loop_enable;
    assign force_black = ctl.force_black;
    assign vscan_off   = ctl.vscan_off;
    assign meas_hi_sel = ctl.loop_enable && phase_hi;
    assign meas_lo_sel = ctl.loop_enable && !phase_hi;
endmodule

// File: rtl/cathode_cal_seq_chk.sv
module cathode_cal_seq_chk (
    input logic clk,
    input logic rst,
    input logic field_pulse,
    input logic loop_stable,
    input logic host_hold,
    input logic timed_release,
    input logic service_mode,
    input logic rgb_blank,
    input logic settle_flag,
    input logic meas_hi_sel,
    input logic meas_lo_sel,
    input logic leak_meas,
    input logic loop_enable,
    input logic force_black,
    input logic vscan_off
);
    // R2
    meas_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        loop_enable |-> ($countones({meas_hi_sel, meas_lo_sel}) == 1));

    // R2
    meas_swap_chk: assert property (@(posedge clk) disable iff (rst)
        (field_pulse && loop_enable && !service_mode) |=> (meas_hi_sel != $past(meas_hi_sel)));

    // R3
    leak_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        (field_pulse && !service_mode) |=> leak_meas);

    // R4
    auto_release_chk: assert property (@(posedge clk) disable iff (rst)
        (rgb_blank && settle_flag && loop_enable && loop_stable && !host_hold
         && !timed_release && !service_mode) |=> !rgb_blank);

    // R5
    host_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (rgb_blank && !settle_flag && host_hold && !service_mode) |=> rgb_blank);

    // R7
    service_chk: assert property (@(posedge clk) disable iff (rst)
        service_mode |=> (force_black && vscan_off && !loop_enable && rgb_blank));

    // R9
    stay_released_chk: assert property (@(posedge clk) disable iff (rst)
        (!rgb_blank && !service_mode) |=> !rgb_blank);
endmodule

bind cathode_cal_seq cathode_cal_seq_chk u_chk (.*);

// File: tb/cathode_cal_seq_test.sv
module cathode_cal_seq_test;
    localparam int DELAY = 64;
    localparam int FPER  = 5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic field_pulse = 1'b0, loop_stable = 1'b0, host_hold = 1'b0;
    logic timed_release = 1'b0, service_mode = 1'b0;
    logic rgb_blank, settle_flag, meas_hi_sel, meas_lo_sel, leak_meas;
    logic loop_enable, force_black, vscan_off;

    int checks = 0;
    int fails  = 0;
    bit done_flag = 1'b0;

    always #10 clk = ~clk;

    cathode_cal_seq #(.FIELD_DELAY(DELAY)) uut (
        .clk(clk), .rst(rst), .field_pulse(field_pulse), .loop_stable(loop_stable),
        .host_hold(host_hold), .timed_release(timed_release), .service_mode(service_mode),
        .rgb_blank(rgb_blank), .settle_flag(settle_flag), .meas_hi_sel(meas_hi_sel),
        .meas_lo_sel(meas_lo_sel), .leak_meas(leak_meas), .loop_enable(loop_enable),
        .force_black(force_black), .vscan_off(vscan_off)
    );

    // behavioural model: 0 blanked, 1 held by host, 2 released, 3 service
    int m_state = 0;
    int m_phase = 1;
    int m_cnt   = 0;
    int m_leak  = 0;

    always @(posedge clk) begin
        if (rst) begin
            m_state = 0; m_phase = 1; m_cnt = 0; m_leak = 0;
        end else begin
            m_leak = (field_pulse && !service_mode) ? 1 : 0;
            if (service_mode) begin
                m_state = 3; m_cnt = 0;
            end else if (m_state == 3) begin
                m_state = 0; m_cnt = 0; m_phase = 1;
            end else begin
                if (field_pulse) m_phase = 1 - m_phase;
                if (m_state == 0) begin
                    if (timed_release) begin
                        if (field_pulse) begin
                            if (m_cnt == DELAY - 1) begin m_state = 2; m_cnt = 0; end
                            else m_cnt++;
                        end
                    end else begin
                        m_cnt = 0;
                        if (loop_stable) m_state = host_hold ? 1 : 2;
                    end
                end else if (m_state == 1) begin
                    if (!host_hold) m_state = 2;
                end
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, act, exp);
        end
    endtask

    // per-cycle comparison against the model, away from the rising edge
    always @(negedge clk) begin
        if (!rst && !done_flag) begin
            int en;
            en = (m_state != 3) ? 1 : 0;
            chk(rgb_blank == (m_state != 2), "R4/R5/R6/R9 rgb_blank", rgb_blank, m_state != 2);
            chk(settle_flag == (m_state == 0 || m_state == 3), "R5 settle_flag",
                settle_flag, m_state == 0 || m_state == 3);
            chk(meas_hi_sel == (en == 1 && m_phase == 1), "R2 meas_hi_sel",
                meas_hi_sel, en == 1 && m_phase == 1);
            chk(meas_lo_sel == (en == 1 && m_phase == 0), "R2 meas_lo_sel",
                meas_lo_sel, en == 1 && m_phase == 0);
            chk(leak_meas == m_leak[0], "R3 leak_meas", leak_meas, m_leak);
            chk(loop_enable == en[0], "R7 loop_enable", loop_enable, en);
            chk(force_black == (m_state == 3), "R7 force_black", force_black, m_state == 3);
            chk(vscan_off == (m_state == 3), "R7 vscan_off", vscan_off, m_state == 3);
        end
    end

    // field pulse generator
    initial begin
        @(negedge clk);
        forever begin
            repeat (FPER - 1) @(negedge clk);
            field_pulse = 1'b1;
            @(negedge clk);
            field_pulse = 1'b0;
        end
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done_flag) begin
            done_flag = 1'b1;
            checks++; fails++;
            $display("FAIL watchdog: actual 0 expected 1 (run completed)");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        wait_cyc(3);
        // R1 reset state
        chk(rgb_blank && settle_flag && loop_enable && meas_hi_sel && !meas_lo_sel
            && !leak_meas && !force_black && !vscan_off, "R1 reset outputs",
            {rgb_blank, settle_flag, loop_enable, meas_hi_sel, meas_lo_sel}, 5'b11110);
        rst = 1'b0;
        wait_cyc(1);
        chk(rgb_blank && settle_flag && meas_hi_sel, "R1 after reset", rgb_blank, 1);
        wait_cyc(12);
        // R4 automatic release
        loop_stable = 1'b1;
        wait_cyc(1);
        chk(!rgb_blank && !settle_flag, "R4 auto release", rgb_blank, 0);
        // R9 stays released when loop_stable drops or host_hold rises
        loop_stable = 1'b0; host_hold = 1'b1;
        wait_cyc(15);
        chk(!rgb_blank, "R9 stays released", rgb_blank, 0);
        host_hold = 1'b0;
        // R7 service
        service_mode = 1'b1;
        wait_cyc(11);
        chk(force_black && vscan_off && !loop_enable && rgb_blank
            && !meas_hi_sel && !meas_lo_sel, "R7 service outputs",
            {force_black, vscan_off, loop_enable}, 3'b110);
        // R8 restart (host policy prepared)
        host_hold = 1'b1;
        service_mode = 1'b0;
        wait_cyc(1);
        chk(rgb_blank && settle_flag && meas_hi_sel, "R8 restart blanked", rgb_blank, 1);
        wait_cyc(7);
        // R5 host-held release
        loop_stable = 1'b1;
        wait_cyc(1);
        chk(!settle_flag && rgb_blank, "R5 flag low, still blanked", rgb_blank, 1);
        wait_cyc(20);
        chk(rgb_blank, "R5 held by host", rgb_blank, 1);
        host_hold = 1'b0;
        wait_cyc(1);
        chk(!rgb_blank, "R5 host release", rgb_blank, 0);
        // R6 timed release, loop_stable ignored
        service_mode = 1'b1;
        wait_cyc(3);
        timed_release = 1'b1;
        service_mode = 1'b0;
        wait_cyc(FPER * 20);
        // drop and reassert to clear the count
        timed_release = 1'b0; loop_stable = 1'b0;
        wait_cyc(3);
        chk(rgb_blank, "R6 no release while counting", rgb_blank, 1);
        timed_release = 1'b1; loop_stable = 1'b1;
        wait_cyc(FPER * (DELAY - 2));
        chk(rgb_blank, "R6 blanked before delay", rgb_blank, 1);
        wait_cyc(FPER * 3);
        chk(!rgb_blank, "R6 released after delay", rgb_blank, 0);
        wait_cyc(10);
        done_flag = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule